// File: doc/BRIEF.md
# Fixed-Latency Pipelined Word RAM

This block is a word-addressed memory that answers requests on a 32-bit pipelined Wishbone bus. It takes a new request in every clock cycle in which both the cycle and strobe inputs are high. It never stalls. Every accepted request, read or write, produces exactly one acknowledge pulse with a data word. That pulse appears a fixed number of clocks later, set by the `DELAY` parameter. Any number of transactions up to `DELAY` can be in flight at once.

The storage holds the smallest power of two that is at least `MEM_WORDS` words. The low address bits select the word, so addresses beyond the depth wrap around. Writes honour four byte-select lanes. A write also returns the stored word as it stands after the write, with the merged bytes. The block suits bus masters and interconnects that must be exercised against a slave with deep, predictable response latency.

Top module: `wbr_pipe_ram`

## Requirements
- R1: The storage depth is 2^ceil(log2(MEM_WORDS)) words, which is 128 for the default of 100. Only the low log2(depth) address bits select a word, so addresses 2, 130 and 0x80000002 all reach the same word.
- R2: The stall output is 0 in every cycle, including reset.
- R3: A request accepted in cycle c gives an ack high for exactly one cycle, in cycle c+DELAY. Back-to-back requests give back-to-back acks in acceptance order.
- R4: A cycle with no accepted request gives, DELAY cycles later, ack low and read data 0.
- R5: The data returned for a write is the word stored at that address after the write is applied.
- R6: The data returned for a read is the word stored at that address when the read is accepted, including a write accepted in the previous cycle.
- R7: Select bit i (i = 0..3) enables data bits 8i+7 down to 8i. Bytes whose select bit is 0 keep their old value, and a write with select 0 changes nothing.
- R8: A request is accepted only when cyc and stb are both high. With either one low there is no ack and no write. we=1 selects a write and we=0 a read.
- R9: Responses already in flight still come out at their scheduled cycles after cyc drops.
- R10: Synchronous reset removes every pending ack and clears the storage to zero. While reset is held, ack is 0 and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock, rising edge |
| i_rst | input | 1 | Synchronous reset, active high |
| i_cyc | input | 1 | Bus cycle active |
| i_stb | input | 1 | Request strobe |
| i_we | input | 1 | 1 = write, 0 = read |
| i_addr | input | ADDR_W | Word address; low bits used, upper bits ignored |
| i_wdata | input | 32 | Write data |
| i_sel | input | 4 | Byte-lane enables for writes |
| o_ack | output | 1 | Response strobe, DELAY cycles after the request |
| o_stall | output | 1 | Always 0 |
| o_rdata | output | 32 | Response data; 0 when o_ack is low |

## Verification
The bench goes after these corner cases:
- Partial byte selects, including select 0. A design with a lane swapped or an unmasked write returns a word with the wrong bytes.
- A strobe without cyc, and cyc without a strobe. A design that decodes only one of them writes the memory or raises a stray ack.
- Addresses above the requested word count and above the depth. These catch a depth that is not rounded up, or an address that is not masked.
- A read in the cycle right after a write to the same word, and a run of back-to-back requests followed by a drop of cyc. A wrong ring index shifts acks by a cycle, and a flush on cyc loses the tail of the run.
- A reset taken while responses are pending. A design that clears only the pointers lets stale acks or stale data escape.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // One slot of the response delay line
    typedef struct packed {
        logic  ack;
        word_t data;
    } resp_t;
endpackage

// File: rtl/wbr_lane_merge.sv
module wbr_lane_merge
    import wbr_pkg::*;
(
    input  word_t  old_word,
    input  word_t  new_word,
    input  lanes_t lane_en,
    output word_t  merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_word[g*LANE_W +: LANE_W]
                                                       : old_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/wbr_store.sv
module wbr_store
    import wbr_pkg::*;
#(
    parameter int unsigned IDX_W = 7,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    input  lanes_t           sel,
    output word_t            old_word,
    output word_t            new_word
);
    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    assign old_word = mem_q[idx];

    wbr_lane_merge u_merge (
        .old_word (old_word),
        .new_word (wdata),
        .lane_en  (sel),
        .merged   (new_word)
    );

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[idx] = new_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/wbr_delay_line.sv
module wbr_delay_line
    import wbr_pkg::*;
#(
    parameter int unsigned DELAY = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  resp_t in_slot,
    output resp_t out_slot
);
    resp_t out_q;
    resp_t out_d;

    assign out_slot = out_q;

    if (DELAY <= 1) begin : g_direct
        always_comb begin
            out_d = in_slot;
        end
    end else begin : g_ring
        localparam int unsigned RW   = $clog2(DELAY);
        localparam int unsigned RLEN = 1 << RW;
        localparam logic [RW-1:0] BACK = RW'(DELAY - 1);

        resp_t         ring_q [RLEN];
        resp_t         ring_d [RLEN];
        logic [RW-1:0] wp_q;
        logic [RW-1:0] wp_d;
        logic [RW-1:0] rp;

        // The slot written DELAY-1 edges ago feeds the output register
        assign rp = wp_q - BACK;

        always_comb begin
            ring_d       = ring_q;
            ring_d[wp_q] = in_slot;
            wp_d         = wp_q + 1'b1;
            out_d        = ring_q[rp];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < RLEN; i++) begin
                    ring_q[i] <= '0;
                end
                wp_q <= '0;
            end else begin
                ring_q <= ring_d;
                wp_q   <= wp_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end
endmodule

// File: rtl/wbr_pipe_ram.sv
module wbr_pipe_ram
    import wbr_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 100,
    parameter int unsigned DELAY     = 3,
    parameter int unsigned ADDR_W    = 32
) (
    input  logic              i_clk,
    input  logic              i_rst,
    input  logic              i_cyc,
    input  logic              i_stb,
    input  logic              i_we,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [31:0]       i_wdata,
    input  logic [3:0]        i_sel,
    output logic              o_ack,
    output logic              o_stall,
    output logic [31:0]       o_rdata
);
    localparam int unsigned IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

    typedef struct packed {
        logic             take;
        logic             write;
        logic [IDX_W-1:0] idx;
    } dec_t;

    dec_t  dec;
    word_t old_word;
    word_t new_word;
    resp_t slot_d;
    resp_t slot_q;

    if (ADDR_W > IDX_W) begin : g_hi
        logic unused_addr_hi;
        assign unused_addr_hi = ^i_addr[ADDR_W-1:IDX_W];
    end

    always_comb begin
        dec.take  = i_cyc & i_stb;
        dec.write = i_cyc & i_stb & i_we;
        dec.idx   = i_addr[IDX_W-1:0];

        slot_d.ack  = dec.take;
        slot_d.data = '0;
        if (dec.take) begin
            slot_d.data = dec.write ? new_word : old_word;
        end
    end

    wbr_store #(.IDX_W(IDX_W)) u_store (
        .clk      (i_clk),
        .rst      (i_rst),
        .wr_en    (dec.write),
        .idx      (dec.idx),
        .wdata    (i_wdata),
        .sel      (i_sel),
        .old_word (old_word),
        .new_word (new_word)
    );

    wbr_delay_line #(.DELAY(DELAY)) u_delay (
        .clk      (i_clk),
        .rst      (i_rst),
        .in_slot  (slot_d),
        .out_slot (slot_q)
    );

    assign o_ack   = slot_q.ack;
    assign o_rdata = slot_q.data;
    assign o_stall = 1'b0;
endmodule

// File: rtl/wbr_pipe_ram_chk.sv
module wbr_pipe_ram_chk #(
    parameter int unsigned DELAY = 3,
    parameter int unsigned IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc,
    input logic             stb,
    input logic             we,
    input logic [IDX_W-1:0] idx,
    input logic [31:0]      wdata,
    input logic [3:0]       sel,
    input logic             ack,
    input logic [31:0]      rdata
);
    typedef struct packed {
        logic        req;
        logic        echo;
        logic        raw;
        logic [31:0] exp;
    } hist_t;

    hist_t            hist_q [DELAY];
    hist_t            cur;
    logic             pw_v_q;
    logic [IDX_W-1:0] pw_idx_q;
    logic [31:0]      pw_dat_q;
    logic             take;
    logic             full_wr;

    assign take    = cyc & stb;
    assign full_wr = take & we & (sel == 4'hF);

    always_comb begin
        cur.req  = take;
        cur.echo = full_wr;
        cur.raw  = take & ~we & pw_v_q & (pw_idx_q == idx);
        cur.exp  = full_wr ? wdata : pw_dat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DELAY; i++) begin
                hist_q[i] <= '0;
            end
            pw_v_q   <= 1'b0;
            pw_idx_q <= '0;
            pw_dat_q <= '0;
        end else begin
            hist_q[0] <= cur;
            for (int i = 1; i < DELAY; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
            pw_v_q   <= full_wr;
            pw_idx_q <= idx;
            pw_dat_q <= wdata;
        end
    end

    // R3 and R8: an ack appears exactly where an accepted request is due
    p_ack_latency_r3: assert property (@(posedge clk) disable iff (rst)
        ack == hist_q[DELAY-1].req);

    // R4: no ack means zero data
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !ack |-> rdata == 32'h0);

    // R5: a full-lane write echoes its own data
    p_write_echo_r5: assert property (@(posedge clk) disable iff (rst)
        hist_q[DELAY-1].echo |-> rdata == hist_q[DELAY-1].exp);

    // R6: a read right after a full-lane write to the same word sees it
    p_read_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        hist_q[DELAY-1].raw |-> rdata == hist_q[DELAY-1].exp);
endmodule

bind wbr_pipe_ram wbr_pipe_ram_chk #(.DELAY(DELAY), .IDX_W(IDX_W)) u_chk (
    .clk   (i_clk),
    .rst   (i_rst),
    .cyc   (i_cyc),
    .stb   (i_stb),
    .we    (i_we),
    .idx   (i_addr[IDX_W-1:0]),
    .wdata (i_wdata),
    .sel   (i_sel),
    .ack   (o_ack),
    .rdata (o_rdata)
);

// File: tb/wbr_pipe_ram_tb.sv
module wbr_pipe_ram_tb;
    localparam int DLY   = 3;
    localparam int WORDS = 100;
    localparam int DEPTH = 128;

    typedef struct packed {
        logic        cyc;
        logic        stb;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  sel;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 32'd5,        32'h11223344, 4'hF, 8'd5},  // R5 full write
        '{1'b1, 1'b1, 1'b0, 32'd5,        32'h0,        4'hF, 8'd6},  // R6 read after write
        '{1'b1, 1'b1, 1'b1, 32'd5,        32'hAABBCCDD, 4'h5, 8'd7},  // R7 lanes 0,2 -> 11BB33DD
        '{1'b1, 1'b1, 1'b0, 32'd5,        32'h0,        4'h0, 8'd7},  // R7 read back merge
        '{1'b1, 1'b1, 1'b1, 32'd9,        32'hCAFEF00D, 4'h8, 8'd7},  // R7 lane 3 -> CA000000
        '{1'b0, 1'b0, 1'b0, 32'd0,        32'h0,        4'h0, 8'd4},  // R4 idle
        '{1'b1, 1'b0, 1'b1, 32'd9,        32'hFFFFFFFF, 4'hF, 8'd8},  // R8 cyc only
        '{1'b0, 1'b1, 1'b1, 32'd9,        32'hFFFFFFFF, 4'hF, 8'd8},  // R8 stb only
        '{1'b1, 1'b1, 1'b0, 32'd9,        32'h0,        4'hF, 8'd8},  // R8 unchanged CA000000
        '{1'b1, 1'b1, 1'b1, 32'd130,      32'h13572468, 4'hF, 8'd1},  // R1 wraps to 2
        '{1'b1, 1'b1, 1'b0, 32'd2,        32'h0,        4'h0, 8'd1},  // R1
        '{1'b1, 1'b1, 1'b0, 32'h80000002, 32'h0,        4'h0, 8'd1},  // R1 high bits ignored
        '{1'b1, 1'b1, 1'b1, 32'd5,        32'hFFFFFFFF, 4'h0, 8'd7},  // R7 select 0
        '{1'b1, 1'b1, 1'b0, 32'd100,      32'h0,        4'h0, 8'd1},  // R1 above count, below depth
        '{1'b1, 1'b1, 1'b1, 32'h2A,       32'h1234BEEF, 4'h3, 8'd5},  // R5 merged echo 0000BEEF
        '{1'b0, 1'b0, 1'b0, 32'd0,        32'h0,        4'h0, 8'd4},  // R4
        '{1'b0, 1'b0, 1'b0, 32'd0,        32'h0,        4'h0, 8'd4},  // R4
        '{1'b0, 1'b0, 1'b0, 32'd0,        32'h0,        4'h0, 8'd4}   // R4
    };

    logic        i_clk = 1'b0;
    logic        i_rst = 1'b1;
    logic        i_cyc = 1'b0;
    logic        i_stb = 1'b0;
    logic        i_we  = 1'b0;
    logic [31:0] i_addr = '0;
    logic [31:0] i_wdata = '0;
    logic [3:0]  i_sel = '0;
    logic        o_ack;
    logic        o_stall;
    logic [31:0] o_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ref_mem [DEPTH];
    logic        exp_ack [DLY];
    logic [31:0] exp_dat [DLY];
    int          exp_req [DLY];
    int          ack_seen;

    always #5 i_clk = ~i_clk;

    wbr_pipe_ram #(.MEM_WORDS(WORDS), .DELAY(DLY), .ADDR_W(32)) u_dut (
        .i_clk   (i_clk),
        .i_rst   (i_rst),
        .i_cyc   (i_cyc),
        .i_stb   (i_stb),
        .i_we    (i_we),
        .i_addr  (i_addr),
        .i_wdata (i_wdata),
        .i_sel   (i_sel),
        .o_ack   (o_ack),
        .o_stall (o_stall),
        .o_rdata (o_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic check_outputs();
        string atag;
        atag = (exp_req[DLY-1] == 9) ? "R9 ack" : "R3 ack";
        check(atag, {31'b0, o_ack}, {31'b0, exp_ack[DLY-1]});
        check("R2 stall", {31'b0, o_stall}, 32'h0);
        check($sformatf("R%0d data", exp_req[DLY-1]), o_rdata, exp_dat[DLY-1]);
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        for (int i = 0; i < DLY; i++) begin
            exp_ack[i] = 1'b0;
            exp_dat[i] = '0;
            exp_req[i] = 10;
        end
    endtask

    // Called right after a falling edge: drive, clock, then check at the next falling edge
    task automatic drive_cycle(input logic cyc, input logic stb, input logic we,
                               input logic [31:0] addr, input logic [31:0] data,
                               input logic [3:0] sel, input int rq);
        logic        r_ack;
        logic [31:0] r_dat;
        int          idx;
        i_cyc = cyc; i_stb = stb; i_we = we;
        i_addr = addr; i_wdata = data; i_sel = sel;
        r_ack = cyc & stb;
        r_dat = '0;
        idx   = int'(addr[6:0]);
        if (r_ack) begin
            if (we) begin
                for (int b = 0; b < 4; b++) begin
                    if (sel[b]) ref_mem[idx][b*8 +: 8] = data[b*8 +: 8];
                end
            end
            r_dat = ref_mem[idx];
        end
        @(posedge i_clk);
        for (int i = DLY-1; i > 0; i--) begin
            exp_ack[i] = exp_ack[i-1];
            exp_dat[i] = exp_dat[i-1];
            exp_req[i] = exp_req[i-1];
        end
        exp_ack[0] = r_ack;
        exp_dat[0] = r_dat;
        exp_req[0] = r_ack ? rq : 4;
        @(negedge i_clk);
        if (o_ack) ack_seen++;
        check_outputs();
    endtask

    task automatic do_reset();
        i_rst = 1'b1;
        i_cyc = 1'b0; i_stb = 1'b0; i_we = 1'b0;
        model_clear();
        repeat (2) @(posedge i_clk);
        @(negedge i_clk);
        check("R10 ack in reset", {31'b0, o_ack}, 32'h0);
        check("R10 data in reset", o_rdata, 32'h0);
        check("R2 stall in reset", {31'b0, o_stall}, 32'h0);
        i_rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3: watchdog expired, got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        @(negedge i_clk);
        do_reset();

        // Vector table
        for (int v = 0; v < NV; v++) begin
            drive_cycle(VECS[v].cyc, VECS[v].stb, VECS[v].we, VECS[v].addr,
                        VECS[v].data, VECS[v].sel, int'(VECS[v].req));
        end

        // R9: a burst of reads, then cyc drops; all acks still arrive
        ack_seen = 0;
        drive_cycle(1'b1, 1'b1, 1'b0, 32'd5, 32'h0, 4'h0, 9);
        drive_cycle(1'b1, 1'b1, 1'b0, 32'd9, 32'h0, 4'h0, 9);
        drive_cycle(1'b1, 1'b1, 1'b0, 32'd2, 32'h0, 4'h0, 9);
        for (int k = 0; k < DLY + 1; k++) begin
            drive_cycle(1'b0, 1'b1, 1'b0, 32'd0, 32'h0, 4'h0, 9);
        end
        check("R9 ack count after cyc drop", ack_seen, 32'd3);

        // R10: reset with writes in flight flushes acks and clears storage
        drive_cycle(1'b1, 1'b1, 1'b1, 32'd20, 32'h00000055, 4'hF, 10);
        drive_cycle(1'b1, 1'b1, 1'b1, 32'd21, 32'h00000066, 4'hF, 10);
        do_reset();
        ack_seen = 0;
        for (int k = 0; k < DLY + 1; k++) begin
            drive_cycle(1'b0, 1'b0, 1'b0, 32'd0, 32'h0, 4'h0, 10);
        end
        check("R10 no stale ack", ack_seen, 32'd0);
        drive_cycle(1'b1, 1'b1, 1'b0, 32'd20, 32'h0, 4'h0, 10);
        drive_cycle(1'b1, 1'b1, 1'b0, 32'd5, 32'h0, 4'h0, 10);
        for (int k = 0; k < DLY; k++) begin
            drive_cycle(1'b0, 1'b0, 1'b0, 32'd0, 32'h0, 4'h0, 4);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule